// File: doc/BRIEF.md
# Shared-Memory Command Mailbox Engine

This block is a hardware agent that serves processor requests through a small mailbox in shared memory. The processor writes a six-word command record at a fixed word address, clears the response status word and then pulses an event line. On that pulse the engine reads the record through a simple memory port and decodes the operation from the top byte of the first word. It then presents an output or input request to the timed I/O core over a request/done port. When the request is done, it writes a four-word response record. That record starts eight words (0x20 bytes) above the command base.

The status word is always written last and always carries a fixed completion flag in bit 16. A processor that polls the status word can therefore tell "finished with a zero status mask" from "not finished yet". The engine handles one command at a time. An event that arrives while a command is in progress is kept and starts one further pass once the engine returns to idle.

Top module: `mbx_engine`

## Requirements
- R1: While reset is held and after reset is released, with no event, the engine makes no memory access (mem_en_o low) and raises no I/O request (io_req_o low).
- R2: An event pulse makes the engine read the six command words at word addresses BASE+0 to BASE+5, one per cycle, in ascending order. Read data returns one cycle after the read.
- R3: The operation is bits [31:24] of word 0: 0 is output and 1 is input. While io_req_o is high, io_input_o is 1 for input and 0 for output. io_chan_o carries word 0 bits [23:0], io_addr_o carries word 1, io_stamp_o carries {word 3, word 2} and io_data_o carries {word 5, word 4}. io_req_o and these fields stay constant until the cycle in which io_done_i is high.
- R4: The response record is written at word addresses BASE+8 to BASE+11 in this layout: status at +8, data at +9, timestamp low half at +10 and timestamp high half at +11.
- R5: The status word is 0x10000 ORed with the 8-bit status mask that io_status_i gives in the done cycle. Bits 15:8 and 31:17 are zero, so a zero mask still gives a nonzero status.
- R6: For an input command the response data is io_rdata_i and the response timestamp is io_rstamp_i, both taken in the done cycle. For an output command both are written as zero.
- R7: Each command produces exactly four response writes, at +9, +10, +11 and then +8. The status write is the last one.
- R8: Any other operation code raises no I/O request and completes with status 0x10080, data zero and timestamp zero.
- R9: Events that arrive while a command is in progress are kept. Once the current command completes, the engine runs one further command pass, however many such events came.
- R10: The engine does not poll. Without an event, changes to the command record cause no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event pulse from the processor |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | AW | Word address into the shared region |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read |
| io_req_o | output | 1 | Request to the I/O core, held until done |
| io_input_o | output | 1 | 1 for an input request, 0 for output |
| io_chan_o | output | 24 | Channel number |
| io_addr_o | output | 32 | Output address field |
| io_stamp_o | output | 64 | Output timestamp, or input timeout |
| io_data_o | output | 64 | Output data |
| io_done_i | input | 1 | I/O core finished the request this cycle |
| io_status_i | input | 8 | Status mask returned by the I/O core |
| io_rdata_i | input | 32 | Input data returned by the I/O core |
| io_rstamp_i | input | 64 | Captured event time returned by the I/O core |

## Verification
Some properties are checked by assertions on every cycle. Every read stays inside the command record. A held I/O request keeps its fields stable until done. Each status write carries the completion flag and comes straight after the timestamp high-half write. Every event sets the pending latch. The bench scenarios cover what no single cycle can show. They sweep operation codes, channels and I/O latencies and compare the four response words with values computed from the command, and they check the read order. They also check that a burst of events during a command leads to exactly one extra pass, and that edits to the mailbox without an event cause no access at all.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_STORE
    } mbx_state_e;

    localparam int CMD_WORDS  = 6;
    localparam int RESP_OFS   = 8;
    localparam int RESP_WORDS = 4;
    localparam int DONE_BIT   = 16;

    localparam logic [7:0] OP_OUT    = 8'd0;
    localparam logic [7:0] OP_IN     = 8'd1;
    localparam logic [7:0] BAD_FLAGS = 8'h80;

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] chan;
        logic [31:0] addr;
        logic [63:0] stamp;
        logic [63:0] data;
    } mbx_cmd_t;

    typedef struct packed {
        logic [7:0]  flags;
        logic [31:0] data;
        logic [63:0] stamp;
    } mbx_resp_t;

    function automatic logic [31:0] status_word(logic [7:0] flags);
        return (32'd1 << DONE_BIT) | {24'd0, flags};
    endfunction

    // store step 0..3 -> response word offset 1,2,3,0 (status last)
    function automatic logic [1:0] store_ofs(logic [1:0] step);
        return step + 2'd1;
    endfunction

endpackage

// File: rtl/mbx_evt_latch.sv
module mbx_evt_latch (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic take_i,
    output logic pend_o
);
    always_ff @(posedge clk) begin
        if (rst) pend_o <= 1'b0;
        else     pend_o <= (pend_o & ~take_i) | evt_i;
    end

    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (rst)
        evt_i |=> pend_o); // R9
endmodule

// File: rtl/mbx_cmd_regs.sv
module mbx_cmd_regs
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_i,
    input  logic [2:0]  slot_i,
    input  logic [31:0] word_i,
    output mbx_cmd_t    cmd_o
);
    logic [31:0] w [CMD_WORDS];

    for (genvar g = 0; g < CMD_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                                 w[g] <= '0;
            else if (load_i && slot_i == 3'(g))      w[g] <= word_i;
        end
    end

    always_comb begin
        cmd_o.op    = w[0][31:24];
        cmd_o.chan  = w[0][23:0];
        cmd_o.addr  = w[1];
        cmd_o.stamp = {w[3], w[2]};
        cmd_o.data  = {w[5], w[4]};
    end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int AW   = 8,
    parameter int BASE = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pend_i,
    output logic          take_o,
    output logic          mem_en_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    output logic          ld_o,
    output logic [2:0]    ld_slot_o,
    input  mbx_cmd_t      cmd_i,
    output logic          io_req_o,
    input  logic          io_done_i,
    input  logic [7:0]    io_status_i,
    input  logic [31:0]   io_rdata_i,
    input  logic [63:0]   io_rstamp_i
);
    localparam logic [AW-1:0] BASE_A = AW'(BASE);
    localparam logic [AW-1:0] RESP_A = AW'(BASE + RESP_OFS);
    localparam logic [2:0]    LAST_FETCH = 3'(CMD_WORDS);
    localparam logic [2:0]    LAST_STORE = 3'(RESP_WORDS - 1);

    mbx_state_e state;
    logic [2:0] idx;
    mbx_resp_t  resp;
    logic [1:0] ofs;

    always_comb begin
        take_o      = 1'b0;
        mem_en_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = BASE_A;
        mem_wdata_o = '0;
        ld_o        = 1'b0;
        ld_slot_o   = idx - 3'd1;
        io_req_o    = 1'b0;
        ofs         = store_ofs(idx[1:0]);
        unique case (state)
            ST_IDLE:   take_o = pend_i;
            ST_FETCH: begin
                mem_en_o   = (idx < LAST_FETCH);
                mem_addr_o = BASE_A + AW'(idx);
                ld_o       = (idx != 3'd0);
            end
            ST_EXEC:   io_req_o = 1'b1;
            ST_STORE: begin
                mem_en_o   = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = RESP_A + AW'(ofs);
                unique case (ofs)
                    2'd0: mem_wdata_o = status_word(resp.flags);
                    2'd1: mem_wdata_o = resp.data;
                    2'd2: mem_wdata_o = resp.stamp[31:0];
                    2'd3: mem_wdata_o = resp.stamp[63:32];
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            resp  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (pend_i) begin
                    state <= ST_FETCH;
                    idx   <= '0;
                end
                ST_FETCH: begin
                    if (idx == LAST_FETCH) state <= ST_DECODE;
                    else                   idx   <= idx + 3'd1;
                end
                ST_DECODE: begin
                    idx <= '0;
                    if (cmd_i.op == OP_OUT || cmd_i.op == OP_IN) begin
                        state <= ST_EXEC;
                    end else begin
                        resp  <= '{flags: BAD_FLAGS, data: '0, stamp: '0};
                        state <= ST_STORE;
                    end
                end
                ST_EXEC: if (io_done_i) begin
                    resp.flags <= io_status_i;
                    resp.data  <= (cmd_i.op == OP_IN) ? io_rdata_i  : '0;
                    resp.stamp <= (cmd_i.op == OP_IN) ? io_rstamp_i : '0;
                    state      <= ST_STORE;
                end
                ST_STORE: begin
                    if (idx == LAST_STORE) state <= ST_IDLE;
                    else                   idx   <= idx + 3'd1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_READ_IN_RECORD: assert property (@(posedge clk) disable iff (rst)
        (mem_en_o && !mem_we_o) |-> (mem_addr_o >= BASE_A &&
                                     mem_addr_o <  BASE_A + AW'(CMD_WORDS))); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (io_req_o && !io_done_i) |=> io_req_o); // R3
    AST_REQ_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (io_req_o && !io_done_i) |=> ($stable(cmd_i.stamp) && $stable(cmd_i.chan))); // R3
    AST_STATUS_MARK: assert property (@(posedge clk) disable iff (rst)
        (mem_en_o && mem_we_o && mem_addr_o == RESP_A) |-> mem_wdata_o[DONE_BIT]); // R5
    AST_STATUS_LAST: assert property (@(posedge clk) disable iff (rst)
        (mem_en_o && mem_we_o && mem_addr_o == RESP_A) |->
        $past(mem_en_o && mem_we_o && mem_addr_o == RESP_A + AW'(3))); // R7
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
    import mbx_pkg::*;
#(
    parameter int AW   = 8,
    parameter int BASE = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt_i,
    output logic          mem_en_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i,
    output logic          io_req_o,
    output logic          io_input_o,
    output logic [23:0]   io_chan_o,
    output logic [31:0]   io_addr_o,
    output logic [63:0]   io_stamp_o,
    output logic [63:0]   io_data_o,
    input  logic          io_done_i,
    input  logic [7:0]    io_status_i,
    input  logic [31:0]   io_rdata_i,
    input  logic [63:0]   io_rstamp_i
);
    logic       pend, take, ld;
    logic [2:0] ld_slot;
    mbx_cmd_t   cmd;

    mbx_evt_latch u_evt (
        .clk(clk), .rst(rst), .evt_i(evt_i), .take_i(take), .pend_o(pend)
    );

    mbx_cmd_regs u_regs (
        .clk(clk), .rst(rst), .load_i(ld), .slot_i(ld_slot),
        .word_i(mem_rdata_i), .cmd_o(cmd)
    );

    mbx_ctrl #(.AW(AW), .BASE(BASE)) u_ctrl (
        .clk(clk), .rst(rst), .pend_i(pend), .take_o(take),
        .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .ld_o(ld), .ld_slot_o(ld_slot),
        .cmd_i(cmd), .io_req_o(io_req_o), .io_done_i(io_done_i),
        .io_status_i(io_status_i), .io_rdata_i(io_rdata_i),
        .io_rstamp_i(io_rstamp_i)
    );

    assign io_input_o = (cmd.op == OP_IN);
    assign io_chan_o  = cmd.chan;
    assign io_addr_o  = cmd.addr;
    assign io_stamp_o = cmd.stamp;
    assign io_data_o  = cmd.data;
endmodule

// File: tb/tb_mbx_engine.sv
module tb_mbx_engine;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          evt_i = 1'b0;
    logic          mem_en_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [31:0]   mem_wdata_o, mem_rdata_i;
    logic          io_req_o, io_input_o, io_done_i;
    logic [23:0]   io_chan_o;
    logic [31:0]   io_addr_o, io_rdata_i;
    logic [63:0]   io_stamp_o, io_data_o, io_rstamp_i;
    logic [7:0]    io_status_i;

    always #2.5 clk = ~clk;

    mbx_engine #(.AW(AW), .BASE(0)) dut (.*);

    // shared memory model and access logs
    logic [31:0] shm [16];
    logic [AW-1:0] rlog [16];
    logic [AW-1:0] wlog [16];
    int rcnt = 0, wcnt = 0, stcnt = 0, ndone = 0;
    int lat = 0, io_cnt = 0;
    logic        cap_in;
    logic [23:0] cap_chan;
    logic [31:0] cap_addr;
    logic [63:0] cap_stamp, cap_data;

    always @(posedge clk) begin
        if (mem_en_o && mem_we_o) begin
            shm[mem_addr_o] <= mem_wdata_o;
            wlog[wcnt[3:0]] <= mem_addr_o;
            wcnt <= wcnt + 1;
            if (mem_addr_o == 4'd8) stcnt <= stcnt + 1;
        end
        if (mem_en_o && !mem_we_o) begin
            mem_rdata_i <= shm[mem_addr_o];
            rlog[rcnt[3:0]] <= mem_addr_o;
            rcnt <= rcnt + 1;
        end
        if (!io_req_o || io_done_i) io_cnt <= 0;
        else                        io_cnt <= io_cnt + 1;
        if (io_done_i) begin
            ndone     <= ndone + 1;
            cap_in    <= io_input_o;
            cap_chan  <= io_chan_o;
            cap_addr  <= io_addr_o;
            cap_stamp <= io_stamp_o;
            cap_data  <= io_data_o;
        end
    end

    function automatic logic [7:0] mdl_status(logic inp, logic [23:0] ch);
        return {4'd0, ch[3:0]} ^ (inp ? 8'h08 : 8'h00);
    endfunction

    assign io_done_i   = io_req_o && (io_cnt == lat);
    assign io_status_i = mdl_status(io_input_o, io_chan_o);
    assign io_rdata_i  = 32'(io_chan_o) * 32'd3 + io_stamp_o[31:0];
    assign io_rstamp_i = io_stamp_o + 64'd17;

    int checks = 0, errors = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_evt();
        @(negedge clk) evt_i = 1'b1;
        @(negedge clk) evt_i = 1'b0;
    endtask

    task automatic run_cmd(logic [7:0] op, logic [23:0] ch, logic [31:0] ad,
                           logic [63:0] st, logic [63:0] da, int l);
        logic valid, inp;
        logic [7:0] fl;
        int n0;
        @(negedge clk);
        lat = l;
        shm[0] = {op, ch}; shm[1] = ad;
        shm[2] = st[31:0]; shm[3] = st[63:32];
        shm[4] = da[31:0]; shm[5] = da[63:32];
        for (int i = 8; i < 12; i++) shm[i] = '0;
        rcnt = 0; wcnt = 0; n0 = ndone;
        pulse_evt();
        for (int t = 0; t < 200 && shm[8] == 0; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        valid = (op == 8'd0 || op == 8'd1);
        inp   = (op == 8'd1);
        fl    = valid ? mdl_status(inp, ch) : 8'h80;
        chk("R5 status", 64'(shm[8]), 64'(32'h10000 | {24'd0, fl}));
        chk("R6 data", 64'(shm[9]), inp ? 64'(ch * 32'd3 + st[31:0]) : 64'd0);
        chk("R6 stamp", {shm[11], shm[10]}, inp ? st + 64'd17 : 64'd0);
        chk("R2 reads", 64'(rcnt), 64'd6);
        for (int i = 0; i < 6; i++) chk("R2 order", 64'(rlog[i]), 64'(i));
        chk("R7 writes", 64'(wcnt), 64'd4);
        chk("R4 w0", 64'(wlog[0]), 64'd9);
        chk("R4 w1", 64'(wlog[1]), 64'd10);
        chk("R4 w2", 64'(wlog[2]), 64'd11);
        chk("R7 status last", 64'(wlog[3]), 64'd8);
        chk(valid ? "R3 one request" : "R8 no request", 64'(ndone - n0),
            valid ? 64'd1 : 64'd0);
        if (valid) begin
            chk("R3 dir", 64'(cap_in), 64'(inp));
            chk("R3 chan", 64'(cap_chan), 64'(ch));
            chk("R3 addr", 64'(cap_addr), 64'(ad));
            chk("R3 stamp", cap_stamp, st);
            chk("R3 data", cap_data, da);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] ops [4];
        logic [23:0] chans [4];
        int lats [3];
        int s0;
        ops   = '{8'd0, 8'd1, 8'd2, 8'hFF};
        chans = '{24'd0, 24'd5, 24'd12, 24'hABCDEF};
        lats  = '{0, 1, 4};
        for (int i = 0; i < 16; i++) shm[i] = '0;
        repeat (4) @(negedge clk);
        chk("R1 no access in reset", 64'(mem_en_o), 64'd0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 idle mem", 64'(mem_en_o), 64'd0);
        chk("R1 idle io", 64'(io_req_o), 64'd0);
        chk("R1 no reads", 64'(rcnt), 64'd0);

        for (int o = 0; o < 4; o++)
            for (int c = 0; c < 4; c++)
                for (int l = 0; l < 3; l++)
                    run_cmd(ops[o], chans[c], 32'h1000 + 32'(c),
                            64'h0000_0001_0000_0000 * 64'(c + 1) + 64'(l * 11 + o),
                            64'hDEAD_0000_0000_0000 + 64'(o * 7 + c), lats[l]);

        // R10: edit mailbox without an event
        @(negedge clk);
        rcnt = 0; wcnt = 0;
        shm[0] = 32'h0100_0007;
        repeat (40) @(negedge clk);
        chk("R10 no reads", 64'(rcnt), 64'd0);
        chk("R10 no writes", 64'(wcnt), 64'd0);

        // R9: several events while busy -> exactly one extra pass
        lat = 3; s0 = stcnt; rcnt = 0;
        shm[0] = 32'h0000_0003;
        pulse_evt();
        repeat (3) @(negedge clk);
        pulse_evt();
        repeat (2) @(negedge clk);
        pulse_evt();
        repeat (80) @(negedge clk);
        chk("R9 passes", 64'(stcnt - s0), 64'd2);
        chk("R9 reads", 64'(rcnt), 64'd12);
        chk("R9 idle after", 64'(mem_en_o), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule